// File: doc/BRIEF.md
# Module Reset and Interrupt Controller

This block sequences the reset of a pluggable multi-lane module and reports its condition to the host through latched status flags and an active-low interrupt line. A reset request arrives on an asynchronous active-low pin. The pin is synchronized, and only a low level that lasts at least a programmable number of cycles is taken as a reset. While a reset is in force, and while supply power is not good, the block drives a module-wide soft reset and holds every flag at its default value.

Once the reset is released, or once power first becomes good, the block holds the data-not-ready status bit set for a fixed initialization window. At the end of the window it clears data-not-ready and latches a ready flag, which pulls the interrupt line low. Each channel has a latched loss-of-signal flag and a latched transmit-fault flag. Each of these flags sets a bounded number of cycles after its event, stays set until the management slave clears it with a read pulse, and can be kept from driving the interrupt by a mask bit.

Top module: `modrst_irq_ctrl`

## Requirements
- R1: The synchronized reset pin must stay low for at least MIN_LOW_CYC consecutive cycles to cause a reset. A shorter low pulse leaves soft_rst, data_not_ready and every latched flag unchanged.
- R2: While soft_rst is high, data_not_ready is high, and from the next cycle on every loss-of-signal, transmit-fault and ready flag reads 0.
- R3: After a qualified reset pin rises, soft_rst stays high for 4 cycles (2 synchronizer stages plus 2 cycles to release the width check). data_not_ready then stays high for another INIT_CYC cycles and clears after that.
- R4: When power_good rises after power-up, an initialization window of INIT_CYC cycles starts and runs to completion with no pin pulse.
- R5: In the cycle data_not_ready falls, ready_flag sets. It stays set until a clr_ready pulse.
- R6: An event on channel i sets los_flag[i] LOS_LAT_CYC cycles after it is sampled (txf_flag[i]: TXF_LAT_CYC cycles). The flag stays set after the event goes away.
- R7: A clear pulse on a flag's bit drives that flag to 0 in the next cycle. If the event is still present, the flag sets again one cycle after that.
- R8: A flag whose mask bit is 1 does not drive int_n. Setting the mask releases int_n in the next cycle, and clearing the mask drives int_n low again in the next cycle.
- R9: int_n is a registered output. It is low exactly one cycle after any unmasked loss-of-signal flag, any unmasked transmit-fault flag or the ready flag is set, and high one cycle after none is.
- R10: While power_good is low, soft_rst and data_not_ready are held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| pin_reset_n | input | 1 | Asynchronous active-low reset request pin |
| power_good | input | 1 | Supply rails at or above their minimum |
| los_evt | input | N_CH | Per-channel loss-of-signal condition |
| txf_evt | input | N_CH | Per-channel transmit-fault condition |
| los_mask | input | N_CH | 1 keeps the channel's LOS flag from driving int_n |
| txf_mask | input | N_CH | 1 keeps the channel's Tx-fault flag from driving int_n |
| clr_los | input | N_CH | Read-clear pulse per LOS flag |
| clr_txf | input | N_CH | Read-clear pulse per Tx-fault flag |
| clr_ready | input | 1 | Read-clear pulse for the ready flag |
| los_flag | output | N_CH | Latched LOS flags |
| txf_flag | output | N_CH | Latched Tx-fault flags |
| ready_flag | output | 1 | Latched initialization-complete flag |
| data_not_ready | output | 1 | Status bit, high until initialization finishes |
| int_n | output | 1 | Active-low interrupt |
| soft_rst | output | 1 | Module-wide soft reset |

## Verification
The assertions assume that clear pulses and mask bits are synchronous to clk and change only between edges. They also assume that power_good and the event inputs are already synchronous, so that only pin_reset_n needs a synchronizer. The bench drives every input at the falling edge. It holds each event for at least one full cycle and issues clear pulses one cycle wide. It keeps each pin pulse clearly shorter or clearly longer than the qualifying width, so the only boundary it tests is the one R1 names.

// File: rtl/modrst_pkg.sv
package modrst_pkg;

    typedef enum logic [1:0] {
        SEQ_WAIT_PWR = 2'd0,
        SEQ_PIN_RST  = 2'd1,
        SEQ_INIT     = 2'd2,
        SEQ_RUN      = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic soft_rst;
        logic not_ready;
        logic done;
    } seq_out_t;

    function automatic int cnt_bits(input int limit);
        int w;
        w = $clog2(limit + 1);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/modrst_pin_qual.sv
module modrst_pin_qual
    import modrst_pkg::*;
#(
    parameter int MIN_LOW_CYC = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic held
);
    localparam int CW = cnt_bits(MIN_LOW_CYC);
    localparam logic [CW-1:0] LIMIT = CW'(MIN_LOW_CYC);

    logic         sync_a;
    logic         sync_b;
    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_a  <= 1'b1;
            sync_b  <= 1'b1;
            low_cnt <= '0;
        end else begin
            sync_a <= pin_n;
            sync_b <= sync_a;
            if (sync_b) begin
                low_cnt <= '0;
            end else if (low_cnt != LIMIT) begin
                low_cnt <= low_cnt + 1'b1;
            end
        end
    end

    assign held = (low_cnt == LIMIT);
endmodule

// File: rtl/modrst_init_seq.sv
module modrst_init_seq
    import modrst_pkg::*;
#(
    parameter int INIT_CYC = 200_000_000
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     power_good,
    input  logic     pin_held,
    output seq_out_t seq_o
);
    localparam int CW = cnt_bits(INIT_CYC);
    localparam logic [CW-1:0] LAST = CW'(INIT_CYC - 1);

    seq_state_e    state;
    seq_state_e    state_nx;
    logic [CW-1:0] icnt;
    logic          window_end;

    assign window_end = (state == SEQ_INIT) && (icnt == LAST);

    always_comb begin
        state_nx = state;
        if (!power_good) begin
            state_nx = SEQ_WAIT_PWR;
        end else if (pin_held) begin
            state_nx = SEQ_PIN_RST;
        end else begin
            case (state)
                SEQ_WAIT_PWR: state_nx = SEQ_INIT;
                SEQ_PIN_RST:  state_nx = SEQ_INIT;
                SEQ_INIT:     state_nx = window_end ? SEQ_RUN : SEQ_INIT;
                default:      state_nx = SEQ_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_WAIT_PWR;
            icnt  <= '0;
        end else begin
            state <= state_nx;
            if (state_nx == SEQ_INIT && state == SEQ_INIT) begin
                icnt <= icnt + 1'b1;
            end else begin
                icnt <= '0;
            end
        end
    end

    always_comb begin
        seq_o.soft_rst  = (state == SEQ_WAIT_PWR) || (state == SEQ_PIN_RST);
        seq_o.not_ready = (state != SEQ_RUN);
        seq_o.done      = window_end && (state_nx == SEQ_RUN);
    end
endmodule

// File: rtl/modrst_flag_cell.sv
module modrst_flag_cell #(
    parameter int LAT_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic soft_rst,
    input  logic evt,
    input  logic clr,
    output logic flag
);
    localparam int DEPTH = (LAT_CYC < 1) ? 1 : LAT_CYC;

    logic [DEPTH-1:0] dline;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst || soft_rst) dline <= '0;
                else                 dline <= evt;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst || soft_rst) dline <= '0;
                else                 dline <= {dline[DEPTH-2:0], evt};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            flag <= 1'b0;
        end else if (clr) begin
            flag <= 1'b0;
        end else if (dline[DEPTH-1]) begin
            flag <= 1'b1;
        end
    end
endmodule

// File: rtl/modrst_irq_ctrl.sv
module modrst_irq_ctrl
    import modrst_pkg::*;
#(
    parameter int N_CH        = 4,
    parameter int MIN_LOW_CYC = 200,
    parameter int INIT_CYC    = 200_000_000,
    parameter int LOS_LAT_CYC = 3,
    parameter int TXF_LAT_CYC = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pin_reset_n,
    input  logic            power_good,
    input  logic [N_CH-1:0] los_evt,
    input  logic [N_CH-1:0] txf_evt,
    input  logic [N_CH-1:0] los_mask,
    input  logic [N_CH-1:0] txf_mask,
    input  logic [N_CH-1:0] clr_los,
    input  logic [N_CH-1:0] clr_txf,
    input  logic            clr_ready,
    output logic [N_CH-1:0] los_flag,
    output logic [N_CH-1:0] txf_flag,
    output logic            ready_flag,
    output logic            data_not_ready,
    output logic            int_n,
    output logic            soft_rst
);
    logic     pin_held;
    seq_out_t seq;
    logic     irq_any;

    modrst_pin_qual #(.MIN_LOW_CYC(MIN_LOW_CYC)) u_qual (
        .clk   (clk),
        .rst   (rst),
        .pin_n (pin_reset_n),
        .held  (pin_held)
    );

    modrst_init_seq #(.INIT_CYC(INIT_CYC)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .power_good (power_good),
        .pin_held   (pin_held),
        .seq_o      (seq)
    );

    assign soft_rst       = seq.soft_rst;
    assign data_not_ready = seq.not_ready;

    generate
        for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
            modrst_flag_cell #(.LAT_CYC(LOS_LAT_CYC)) u_los (
                .clk      (clk),
                .rst      (rst),
                .soft_rst (seq.soft_rst),
                .evt      (los_evt[ch]),
                .clr      (clr_los[ch]),
                .flag     (los_flag[ch])
            );
            modrst_flag_cell #(.LAT_CYC(TXF_LAT_CYC)) u_txf (
                .clk      (clk),
                .rst      (rst),
                .soft_rst (seq.soft_rst),
                .evt      (txf_evt[ch]),
                .clr      (clr_txf[ch]),
                .flag     (txf_flag[ch])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || seq.soft_rst) begin
            ready_flag <= 1'b0;
        end else if (seq.done) begin
            ready_flag <= 1'b1;
        end else if (clr_ready) begin
            ready_flag <= 1'b0;
        end
    end

    assign irq_any = (|(los_flag & ~los_mask)) | (|(txf_flag & ~txf_mask)) | ready_flag;

    always_ff @(posedge clk) begin
        if (rst) int_n <= 1'b1;
        else     int_n <= ~irq_any;
    end
endmodule

// File: rtl/modrst_irq_ctrl_chk.sv
module modrst_irq_ctrl_chk #(
    parameter int N_CH = 4
) (
    input logic            clk,
    input logic            rst,
    input logic [N_CH-1:0] los_mask,
    input logic [N_CH-1:0] txf_mask,
    input logic [N_CH-1:0] clr_los,
    input logic [N_CH-1:0] clr_txf,
    input logic            clr_ready,
    input logic [N_CH-1:0] los_flag,
    input logic [N_CH-1:0] txf_flag,
    input logic            ready_flag,
    input logic            data_not_ready,
    input logic            int_n,
    input logic            soft_rst
);
    logic live;
    assign live = ((los_flag & ~los_mask) != '0) || ((txf_flag & ~txf_mask) != '0) || ready_flag;

    // R2: soft reset always reports not ready
    assert_softrst_dnr_R2: assert property (@(posedge clk) disable iff (rst)
        soft_rst |-> data_not_ready);

    // R2: soft reset empties every flag on the next cycle
    assert_softrst_clears_R2: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (los_flag == '0 && txf_flag == '0 && !ready_flag));

    // R5: ready flag rises together with data_not_ready falling
    assert_ready_done_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_flag) |-> $fell(data_not_ready));

    // R5: ready flag only leaves by clear or soft reset
    assert_ready_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        ready_flag && !clr_ready && !soft_rst |=> ready_flag);

    // R9: interrupt follows the unmasked sources one cycle later
    assert_intn_low_R9: assert property (@(posedge clk) disable iff (rst)
        live |=> !int_n);

    // R8: fully masked or empty sources release the interrupt
    assert_intn_high_R8: assert property (@(posedge clk) disable iff (rst)
        !live |=> int_n);

    generate
        for (genvar i = 0; i < N_CH; i++) begin : g_a
            // R6: LOS flag sticky
            assert_los_sticky_R6: assert property (@(posedge clk) disable iff (rst)
                los_flag[i] && !clr_los[i] && !soft_rst |=> los_flag[i]);
            // R6: Tx-fault flag sticky
            assert_txf_sticky_R6: assert property (@(posedge clk) disable iff (rst)
                txf_flag[i] && !clr_txf[i] && !soft_rst |=> txf_flag[i]);
            // R7: read-clear takes effect next cycle
            assert_los_clear_R7: assert property (@(posedge clk) disable iff (rst)
                clr_los[i] |=> !los_flag[i]);
            assert_txf_clear_R7: assert property (@(posedge clk) disable iff (rst)
                clr_txf[i] |=> !txf_flag[i]);
        end
    endgenerate
endmodule

bind modrst_irq_ctrl modrst_irq_ctrl_chk #(.N_CH(N_CH)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .los_mask       (los_mask),
    .txf_mask       (txf_mask),
    .clr_los        (clr_los),
    .clr_txf        (clr_txf),
    .clr_ready      (clr_ready),
    .los_flag       (los_flag),
    .txf_flag       (txf_flag),
    .ready_flag     (ready_flag),
    .data_not_ready (data_not_ready),
    .int_n          (int_n),
    .soft_rst       (soft_rst)
);

// File: tb/modrst_irq_ctrl_test.sv
module modrst_irq_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NC   = 4;
    localparam int MINL = 8;
    localparam int INIT = 20;
    localparam int LLAT = 3;
    localparam int TLAT = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pin_reset_n = 1'b1;
    logic power_good = 1'b0;
    logic [NC-1:0] los_evt = '0, txf_evt = '0, los_mask = '0, txf_mask = '0;
    logic [NC-1:0] clr_los = '0, clr_txf = '0;
    logic clr_ready = 1'b0;
    logic [NC-1:0] los_flag, txf_flag;
    logic ready_flag, data_not_ready, int_n, soft_rst;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    modrst_irq_ctrl #(.N_CH(NC), .MIN_LOW_CYC(MINL), .INIT_CYC(INIT),
                      .LOS_LAT_CYC(LLAT), .TXF_LAT_CYC(TLAT)) uut (
        .clk(clk), .rst(rst), .pin_reset_n(pin_reset_n), .power_good(power_good),
        .los_evt(los_evt), .txf_evt(txf_evt), .los_mask(los_mask), .txf_mask(txf_mask),
        .clr_los(clr_los), .clr_txf(clr_txf), .clr_ready(clr_ready),
        .los_flag(los_flag), .txf_flag(txf_flag), .ready_flag(ready_flag),
        .data_not_ready(data_not_ready), .int_n(int_n), .soft_rst(soft_rst)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference: mode 0 no power, 1 pin reset, 2 initializing, 3 running
    int m_p1, m_p2, m_low, m_mode, m_icnt;
    int m_lq[NC][$];
    int m_tq[NC][$];
    bit [NC-1:0] m_los, m_txf;
    bit m_ready, m_intn;

    task automatic model_reset();
        m_p1 = 1; m_p2 = 1; m_low = 0; m_mode = 0; m_icnt = 0;
        m_los = '0; m_txf = '0; m_ready = 0; m_intn = 1;
        for (int c = 0; c < NC; c++) begin
            m_lq[c].delete(); m_tq[c].delete();
            for (int k = 0; k < LLAT; k++) m_lq[c].push_back(0);
            for (int k = 0; k < TLAT; k++) m_tq[c].push_back(0);
        end
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (rst) begin
            model_reset();
        end else begin
            bit srst, hold, done;
            int nmode;
            srst = (m_mode <= 1);
            hold = (m_low == MINL);
            m_intn = !(((m_los & ~los_mask) != 0) || ((m_txf & ~txf_mask) != 0) || m_ready);
            done = 0;
            if (!power_good) nmode = 0;
            else if (hold) nmode = 1;
            else if (m_mode <= 1) nmode = 2;
            else if (m_mode == 2 && m_icnt == INIT - 1) begin nmode = 3; done = 1; end
            else nmode = m_mode;
            for (int c = 0; c < NC; c++) begin
                int lo, to;
                lo = m_lq[c].pop_front();
                to = m_tq[c].pop_front();
                if (srst || clr_los[c]) m_los[c] = 0; else if (lo != 0) m_los[c] = 1;
                if (srst || clr_txf[c]) m_txf[c] = 0; else if (to != 0) m_txf[c] = 1;
                m_lq[c].push_back(srst ? 0 : int'(los_evt[c]));
                m_tq[c].push_back(srst ? 0 : int'(txf_evt[c]));
                if (srst) begin
                    for (int k = 0; k < LLAT; k++) m_lq[c][k] = 0;
                    for (int k = 0; k < TLAT; k++) m_tq[c][k] = 0;
                end
            end
            if (srst) m_ready = 0; else if (done) m_ready = 1; else if (clr_ready) m_ready = 0;
            if (nmode == 2 && m_mode == 2) m_icnt = m_icnt + 1; else m_icnt = 0;
            m_mode = nmode;
            if (m_p2 != 0) m_low = 0; else if (m_low != MINL) m_low = m_low + 1;
            m_p2 = m_p1;
            m_p1 = int'(pin_reset_n);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // compare with the reference on every clock, at the falling edge
    always @(negedge clk) begin
        cyc++;
        chk(los_flag == m_los, "R6 model los_flag", int'(los_flag), int'(m_los));
        chk(txf_flag == m_txf, "R7 model txf_flag", int'(txf_flag), int'(m_txf));
        chk(ready_flag == m_ready, "R5 model ready_flag", int'(ready_flag), int'(m_ready));
        chk(int_n == m_intn, "R9 model int_n", int'(int_n), int'(m_intn));
        chk(soft_rst == (m_mode <= 1), "R1 model soft_rst", int'(soft_rst), int'(m_mode <= 1));
        chk(data_not_ready == (m_mode != 3), "R3 model data_not_ready",
            int'(data_not_ready), int'(m_mode != 3));
        if (cyc > 5000) begin
            chk(0, "watchdog", cyc, 5000);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        tick(3);
        chk(soft_rst == 1, "R10 reset state soft_rst", int'(soft_rst), 1);
        chk(data_not_ready == 1, "R10 reset state dnr", int'(data_not_ready), 1);
        chk(int_n == 1, "R9 reset state int_n", int'(int_n), 1);
        rst = 1'b0;
        tick(4);
        chk(soft_rst == 1, "R10 no power soft_rst", int'(soft_rst), 1);
        power_good = 1'b1;
        tick(INIT - 2);
        chk(data_not_ready == 1, "R4 still initializing", int'(data_not_ready), 1);
        tick(8);
        chk(data_not_ready == 0, "R4 init done", int'(data_not_ready), 0);
        chk(ready_flag == 1, "R5 ready set", int'(ready_flag), 1);
        chk(int_n == 0, "R5 int_n low on ready", int'(int_n), 0);
        clr_ready = 1'b1; tick(1); clr_ready = 1'b0;
        tick(2);
        chk(int_n == 1, "R9 int_n released", int'(int_n), 1);

        // LOS on channel 1, short event
        los_evt[1] = 1'b1; tick(1); los_evt[1] = 1'b0;
        tick(8);
        chk(los_flag == 4'b0010, "R6 los latched sticky", int'(los_flag), 2);
        chk(int_n == 0, "R6 int_n on los", int'(int_n), 0);
        los_mask[1] = 1'b1; tick(2);
        chk(int_n == 1, "R8 masked", int'(int_n), 1);
        chk(los_flag[1] == 1, "R8 flag kept under mask", int'(los_flag[1]), 1);
        los_mask[1] = 1'b0; tick(2);
        chk(int_n == 0, "R8 unmasked", int'(int_n), 0);
        clr_los[1] = 1'b1; tick(1); clr_los[1] = 1'b0;
        tick(2);
        chk(los_flag == 0, "R7 los cleared", int'(los_flag), 0);
        chk(int_n == 1, "R9 int_n after clear", int'(int_n), 1);

        // persistent Tx fault on channel 2
        txf_evt[2] = 1'b1; tick(6);
        chk(txf_flag == 4'b0100, "R6 txf latched", int'(txf_flag), 4);
        clr_txf[2] = 1'b1; tick(1); clr_txf[2] = 1'b0;
        chk(txf_flag[2] == 0, "R7 txf cleared", int'(txf_flag[2]), 0);
        tick(1);
        chk(txf_flag[2] == 1, "R7 txf sets again", int'(txf_flag[2]), 1);
        txf_evt[2] = 1'b0; tick(4);
        clr_txf[2] = 1'b1; tick(1); clr_txf[2] = 1'b0;
        tick(3);
        chk(txf_flag == 0 && int_n == 1, "R7 txf gone", int'(txf_flag), 0);

        // short pin pulse is ignored
        los_evt[0] = 1'b1; tick(1); los_evt[0] = 1'b0; tick(6);
        pin_reset_n = 1'b0;
        for (int k = 0; k < MINL - 3; k++) begin
            tick(1);
            chk(soft_rst == 0, "R1 short pulse soft_rst", int'(soft_rst), 0);
        end
        pin_reset_n = 1'b1;
        tick(6);
        chk(soft_rst == 0 && data_not_ready == 0, "R1 short pulse dnr", int'(data_not_ready), 0);
        chk(los_flag[0] == 1, "R1 flag survives short pulse", int'(los_flag[0]), 1);

        // long pin pulse resets
        pin_reset_n = 1'b0;
        tick(MINL + 4);
        chk(soft_rst == 1, "R1 long pulse soft_rst", int'(soft_rst), 1);
        chk(data_not_ready == 1, "R2 dnr in reset", int'(data_not_ready), 1);
        chk(los_flag == 0 && ready_flag == 0, "R2 flags cleared", int'(los_flag), 0);
        pin_reset_n = 1'b1;
        tick(10);
        chk(soft_rst == 0 && data_not_ready == 1, "R3 initializing", int'(data_not_ready), 1);
        tick(20);
        chk(data_not_ready == 0, "R3 ready after window", int'(data_not_ready), 0);
        chk(ready_flag == 1, "R5 ready after pin reset", int'(ready_flag), 1);

        // power loss
        power_good = 1'b0; tick(2);
        chk(soft_rst == 1 && data_not_ready == 1, "R10 power lost", int'(soft_rst), 1);
        power_good = 1'b1; tick(INIT + 6);
        chk(data_not_ready == 0, "R4 repower init", int'(data_not_ready), 0);

        tick(2);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule